// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This unit holds the four arithmetic condition flags (negative, zero, carry, overflow) together with a sticky saturation flag, and decides for each issued instruction whether it takes effect. Every instruction carries a 4-bit condition selector. The unit evaluates that selector against the flags as they stand in that cycle. It then raises either an execute strobe or a skip strobe. A skipped instruction occupies its issue slot for exactly that one cycle and needs no flush.

The datapath asks for a flag update through a set-flags enable that carries the new N/Z/C/V values. A saturation event raises the sticky flag, which then stays raised. A status-word write port loads all five flags at once and is the only way to clear the sticky flag. The status word is always readable, with the flags placed at its top five bits. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `pred_unit`

## Requirements
- R1: While reset is held and for as long as no update arrives after it, the status word reads zero and neither exec_o nor skip_o is asserted unless instr_valid is high.
- R2: Selector 14 (always) executes whatever the flags are, and selector 15 (never) always skips.
- R3: Selector 0 executes when Z=1, and selector 1 executes when Z=0.
- R4: Selectors 2/3 execute on C=1/C=0, selectors 4/5 on N=1/N=0, and selectors 6/7 on V=1/V=0.
- R5: Selector 8 executes when C=1 and Z=0, and selector 9 executes in every other case.
- R6: Selectors 10 (N==V), 11 (N!=V), 12 (Z=0 and N==V) and 13 (Z=1 or N!=V) give signed ≥, <, > and ≤ after a compare whose flags come from a subtraction.
- R7: N/Z/C/V change only in a cycle with setflags_en high, and take new_n/new_z/new_c/new_v on the next clock edge. Otherwise they keep their value.
- R8: A sat_event pulse sets Q (bit 27) on the next edge. Q then stays set through flag updates and idle cycles until a status-word write clears it.
- R9: A status-word write loads bits 31..27 as N, Z, C, V, Q on the next edge. It takes priority over a setflags_en or sat_event in the same cycle.
- R10: The execute decision in a cycle uses the flags from before any update requested in that same cycle.
- R11: When instr_valid is high, exactly one of exec_o and skip_o is high in that same cycle. When instr_valid is low, both are low.
- R12: The status word presents N at bit 31, Z at 30, C at 29, V at 28 and Q at 27, and every other bit reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is issued this cycle |
| cond_sel | input | 4 | Condition selector of the issued instruction |
| setflags_en | input | 1 | Request to update N/Z/C/V |
| new_n | input | 1 | New negative flag |
| new_z | input | 1 | New zero flag |
| new_c | input | 1 | New carry flag |
| new_v | input | 1 | New overflow flag |
| sat_event | input | 1 | Saturation occurred; sets the sticky flag |
| sw_wr_en | input | 1 | Status-word write strobe |
| sw_wr_data | input | STATUS_W | Status-word write value (bits 31..27 used) |
| sw_rd_data | output | STATUS_W | Current status word |
| exec_o | output | 1 | Issued instruction executes |
| skip_o | output | 1 | Issued instruction is skipped |

## Verification
The assertions assume two things. First, cond_sel and the update inputs are stable away from the clock edge. Second, whoever drives the update strobes accepts the fixed priority of the write port over set-flags and saturation. Because of this, the hold and sticky properties are stated only for cycles without a status-word write. The bench changes inputs one time unit after a rising edge and samples shortly afterwards. It lets the internal reset synchronizer release before it issues any instruction. It also drives the conflicting same-cycle cases on purpose, so that the priority is exercised rather than avoided.

// File: rtl/pred_pkg.sv
package pred_pkg;

  localparam int COND_W   = 4;
  localparam int NUM_COND = 1 << COND_W;
  localparam int NUM_PAIR = NUM_COND / 2;

  // status-word bit positions of the flags
  localparam int POS_N = 31;
  localparam int POS_Z = 30;
  localparam int POS_C = 29;
  localparam int POS_V = 28;
  localparam int POS_Q = 27;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef enum logic [COND_W-1:0] {
    SEL_EQ = 4'd0,  SEL_NE = 4'd1,  SEL_CS = 4'd2,  SEL_CC = 4'd3,
    SEL_MI = 4'd4,  SEL_PL = 4'd5,  SEL_VS = 4'd6,  SEL_VC = 4'd7,
    SEL_HI = 4'd8,  SEL_LS = 4'd9,  SEL_GE = 4'd10, SEL_LT = 4'd11,
    SEL_GT = 4'd12, SEL_LE = 4'd13, SEL_AL = 4'd14, SEL_NV = 4'd15
  } cond_sel_e;

  // Base (even-code) predicate of selector pair p; odd code is its inverse.
  function automatic logic pair_base(input int p, input nzcv_t f);
    logic r;
    case (p)
      0:       r = f.z;
      1:       r = f.c;
      2:       r = f.n;
      3:       r = f.v;
      4:       r = f.c & ~f.z;
      5:       r = ~(f.n ^ f.v);
      6:       r = ~f.z & ~(f.n ^ f.v);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pred_cond_eval.sv
module pred_cond_eval
  import pred_pkg::*;
(
  input  nzcv_t             flags,
  input  logic [COND_W-1:0] sel,
  output logic              pass
);

  logic [NUM_COND-1:0] hit;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    if (p == NUM_PAIR - 1) begin : g_always_never
      assign hit[2*p]   = 1'b1;
      assign hit[2*p+1] = 1'b0;
    end else begin : g_true_false
      logic base;
      assign base       = pair_base(p, flags);
      assign hit[2*p]   = base;
      assign hit[2*p+1] = ~base;
    end
  end

  assign pass = hit[sel];

endmodule

// File: rtl/pred_flag_bank.sv
module pred_flag_bank
  import pred_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_en,
  input  nzcv_t ld_val,
  input  logic  upd_en,
  input  nzcv_t upd_val,
  output nzcv_t flags_q
);

  nzcv_t flags_d;
  logic  flags_ce;

  always_comb begin
    flags_ce = ld_en | upd_en;
    flags_d  = flags_q;
    if (ld_en) begin
      flags_d = ld_val;
    end else if (upd_en) begin
      flags_d = upd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_ce) begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/pred_sticky.sv
module pred_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_en,
  input  logic ld_val,
  input  logic set_evt,
  output logic q
);

  logic q_d;
  logic q_ce;

  always_comb begin
    q_ce = ld_en | set_evt;
    q_d  = ld_en ? ld_val : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (q_ce) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/pred_unit.sv
module pred_unit
  import pred_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  input  logic [COND_W-1:0]   cond_sel,
  input  logic                setflags_en,
  input  logic                new_n,
  input  logic                new_z,
  input  logic                new_c,
  input  logic                new_v,
  input  logic                sat_event,
  input  logic                sw_wr_en,
  input  logic [STATUS_W-1:0] sw_wr_data,
  output logic [STATUS_W-1:0] sw_rd_data,
  output logic                exec_o,
  output logic                skip_o
);

  // reset: asserted asynchronously, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // unpack write port and update request
  nzcv_t wr_flags;
  nzcv_t upd_flags;
  nzcv_t flags_q;
  logic  q_flag;
  logic  wr_bits_unused;

  assign wr_flags  = '{n: sw_wr_data[POS_N], z: sw_wr_data[POS_Z],
                       c: sw_wr_data[POS_C], v: sw_wr_data[POS_V]};
  assign upd_flags = '{n: new_n, z: new_z, c: new_c, v: new_v};
  assign wr_bits_unused = ^sw_wr_data;

  pred_flag_bank i_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_en   (sw_wr_en),
    .ld_val  (wr_flags),
    .upd_en  (setflags_en),
    .upd_val (upd_flags),
    .flags_q (flags_q)
  );

  pred_sticky i_sticky (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_en   (sw_wr_en),
    .ld_val  (sw_wr_data[POS_Q]),
    .set_evt (sat_event),
    .q       (q_flag)
  );

  // decision from registered (pre-update) flags
  logic cond_pass;

  pred_cond_eval i_eval (
    .flags (flags_q),
    .sel   (cond_sel),
    .pass  (cond_pass)
  );

  always_comb begin
    exec_o = instr_valid &  cond_pass;
    skip_o = instr_valid & ~cond_pass;
  end

  always_comb begin
    sw_rd_data        = '0;
    sw_rd_data[POS_N] = flags_q.n;
    sw_rd_data[POS_Z] = flags_q.z;
    sw_rd_data[POS_C] = flags_q.c;
    sw_rd_data[POS_V] = flags_q.v;
    sw_rd_data[POS_Q] = q_flag;
  end

endmodule

// File: rtl/pred_unit_chk.sv
module pred_unit_chk
  import pred_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                instr_valid,
  input logic [COND_W-1:0]   cond_sel,
  input logic                setflags_en,
  input logic                new_n,
  input logic                new_z,
  input logic                new_c,
  input logic                new_v,
  input logic                sat_event,
  input logic                sw_wr_en,
  input logic [STATUS_W-1:0] sw_wr_data,
  input logic [STATUS_W-1:0] sw_rd_data,
  input logic                exec_o,
  input logic                skip_o
);

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> (exec_o ^ skip_o));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!exec_o && !skip_o));

  assert_always_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && cond_sel == 4'd14) |-> exec_o);

  assert_never_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && cond_sel == 4'd15) |-> skip_o);

  assert_eq_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && cond_sel == 4'd0) |-> (exec_o == sw_rd_data[POS_Z]));

  assert_ge_signed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && cond_sel == 4'd10) |-> (exec_o == (sw_rd_data[POS_N] == sw_rd_data[POS_V])));

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!setflags_en && !sw_wr_en) |=> $stable(sw_rd_data[POS_N:POS_V]));

  assert_flags_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (setflags_en && !sw_wr_en) |=> (sw_rd_data[POS_N:POS_V] == $past({new_n, new_z, new_c, new_v})));

  assert_sticky_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_data[POS_Q] && !sw_wr_en) |=> sw_rd_data[POS_Q]);

  assert_sat_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_event && !sw_wr_en) |=> sw_rd_data[POS_Q]);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (sw_rd_data[POS_N:POS_Q] == $past(sw_wr_data[POS_N:POS_Q])));

  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rd_data[POS_Q-1:0] == '0);

endmodule

bind pred_unit pred_unit_chk #(.STATUS_W(STATUS_W)) i_pred_unit_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .instr_valid (instr_valid),
  .cond_sel    (cond_sel),
  .setflags_en (setflags_en),
  .new_n       (new_n),
  .new_z       (new_z),
  .new_c       (new_c),
  .new_v       (new_v),
  .sat_event   (sat_event),
  .sw_wr_en    (sw_wr_en),
  .sw_wr_data  (sw_wr_data),
  .sw_rd_data  (sw_rd_data),
  .exec_o      (exec_o),
  .skip_o      (skip_o)
);

// File: tb/test_pred_unit.sv
module test_pred_unit;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          instr_valid;
  logic [3:0]    cond_sel;
  logic          setflags_en;
  logic          new_n, new_z, new_c, new_v;
  logic          sat_event;
  logic          sw_wr_en;
  logic [SW-1:0] sw_wr_data;
  logic [SW-1:0] sw_rd_data;
  logic          exec_o, skip_o;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of flags {N,Z,C,V,Q}
  logic [4:0] mdl;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_unit i_pred_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .cond_sel(cond_sel),
    .setflags_en(setflags_en), .new_n(new_n), .new_z(new_z), .new_c(new_c),
    .new_v(new_v), .sat_event(sat_event), .sw_wr_en(sw_wr_en),
    .sw_wr_data(sw_wr_data), .sw_rd_data(sw_rd_data),
    .exec_o(exec_o), .skip_o(skip_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic ref_cond(input logic [3:0] s, input logic [4:0] f);
    logic n, z, c, v;
    n = f[4]; z = f[3]; c = f[2]; v = f[1];
    case (s)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] s);
    if (s >= 4'd14) return "R2";
    if (s <= 4'd1)  return "R3";
    if (s <= 4'd7)  return "R4";
    if (s <= 4'd9)  return "R5";
    return "R6";
  endfunction

  function automatic logic [31:0] word_of(input logic [4:0] f);
    return {f, 27'd0};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_word(input string req);
    chk(sw_rd_data == word_of(mdl), req, sw_rd_data, word_of(mdl));
  endtask

  task automatic write_sw(input logic [4:0] f);
    sw_wr_en   = 1'b1;
    sw_wr_data = {f, 27'h5A5A5A5};
    tick();
    sw_wr_en   = 1'b0;
    sw_wr_data = '0;
    mdl = f;
  endtask

  task automatic check_issue(input logic [3:0] s, input string req);
    logic e;
    instr_valid = 1'b1;
    cond_sel = s;
    #1;
    e = ref_cond(s, mdl);
    chk(exec_o == e && skip_o == !e, req, {30'd0, exec_o, skip_o}, {30'd0, e, !e});
    instr_valid = 1'b0;
  endtask

  task automatic t_reset();
    // R1: during reset
    chk(sw_rd_data == '0, "R1", sw_rd_data, 32'd0);
    chk(!exec_o && !skip_o, "R1", {exec_o, skip_o}, 32'd0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    mdl = '0;
    chk(sw_rd_data == '0, "R1", sw_rd_data, 32'd0);
    check_issue(4'd0, "R1");
    tick();
  endtask

  task automatic t_all_conditions();
    for (int f = 0; f < 16; f++) begin
      write_sw({f[3:0], 1'b0});
      for (int s = 0; s < 16; s++) begin
        check_issue(s[3:0], tag_of(s[3:0]));
        tick();
      end
    end
  endtask

  task automatic t_compare();
    logic [31:0] a_list [6] = '{32'd5, 32'd3, 32'd4, 32'hFFFFFFFE, 32'h7FFFFFFF, 32'h80000000};
    logic [31:0] b_list [6] = '{32'd3, 32'd5, 32'd4, 32'd1, 32'hFFFFFFFF, 32'd1};
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a, b, r;
      logic gt, lt, eq;
      a = a_list[i]; b = b_list[i];
      r = a - b;
      setflags_en = 1'b1;
      new_n = r[31];
      new_z = (r == 0);
      new_c = (a >= b);
      new_v = (a[31] != b[31]) && (r[31] != a[31]);
      tick();
      setflags_en = 1'b0;
      mdl[4:1] = {new_n, new_z, new_c, new_v};
      gt = $signed(a) > $signed(b);
      lt = $signed(a) < $signed(b);
      eq = (a == b);
      cond_sel = 4'd12; instr_valid = 1'b1; #1;
      chk(exec_o == gt, "R6 GT", {31'd0, exec_o}, {31'd0, gt});
      cond_sel = 4'd11; #1;
      chk(exec_o == lt, "R6 LT", {31'd0, exec_o}, {31'd0, lt});
      cond_sel = 4'd10; #1;
      chk(exec_o == !lt, "R6 GE", {31'd0, exec_o}, {31'd0, !lt});
      cond_sel = 4'd13; #1;
      chk(exec_o == !gt, "R6 LE", {31'd0, exec_o}, {31'd0, !gt});
      cond_sel = 4'd0; #1;
      chk(exec_o == eq, "R3 EQ", {31'd0, exec_o}, {31'd0, eq});
      cond_sel = 4'd1; #1;
      chk(exec_o == !eq, "R3 NE", {31'd0, exec_o}, {31'd0, !eq});
      instr_valid = 1'b0;
      tick();
    end
  endtask

  task automatic t_hold_and_update();
    write_sw(5'b10100);
    check_word("R9");
    // no setflags: flags hold even with instructions and new_* toggling
    new_n = 1'b0; new_z = 1'b1; new_c = 1'b0; new_v = 1'b1;
    for (int k = 0; k < 4; k++) begin
      check_issue(k[3:0], "R7");
      tick();
      check_word("R7");
    end
    setflags_en = 1'b1;
    tick();
    setflags_en = 1'b0;
    mdl[4:1] = 4'b0101;
    check_word("R7");
  endtask

  task automatic t_sticky();
    write_sw(5'b00000);
    sat_event = 1'b1;
    tick();
    sat_event = 1'b0;
    mdl[0] = 1'b1;
    check_word("R8");
    setflags_en = 1'b1;
    new_n = 1'b1; new_z = 1'b0; new_c = 1'b1; new_v = 1'b0;
    tick();
    setflags_en = 1'b0;
    mdl[4:1] = 4'b1010;
    check_word("R8");
    tick(); tick();
    check_word("R8");
  endtask

  task automatic t_write_priority();
    // write with Q=0 clears sticky despite concurrent sat_event and setflags
    setflags_en = 1'b1;
    new_n = 1'b1; new_z = 1'b1; new_c = 1'b1; new_v = 1'b1;
    sat_event = 1'b1;
    write_sw(5'b01010);
    setflags_en = 1'b0;
    sat_event = 1'b0;
    check_word("R9");
    // all ones written: reserved bits still read zero
    write_sw(5'b11111);
    chk(sw_rd_data == 32'hF8000000, "R12", sw_rd_data, 32'hF8000000);
  endtask

  task automatic t_pre_update();
    write_sw(5'b01000);                 // Z=1
    setflags_en = 1'b1;
    new_n = 1'b0; new_z = 1'b0; new_c = 1'b0; new_v = 1'b0;
    instr_valid = 1'b1; cond_sel = 4'd0; #1;
    chk(exec_o == 1'b1, "R10", {31'd0, exec_o}, 32'd1);
    tick();
    setflags_en = 1'b0;
    mdl[4:1] = 4'b0000;
    #1;
    chk(exec_o == 1'b0 && skip_o == 1'b1, "R10", {exec_o, skip_o}, 32'd1);
    instr_valid = 1'b0;
    tick();
  endtask

  task automatic t_idle();
    for (int s = 0; s < 16; s += 5) begin
      instr_valid = 1'b0;
      cond_sel = s[3:0];
      #1;
      chk(!exec_o && !skip_o, "R11", {exec_o, skip_o}, 32'd0);
    end
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    instr_valid = 1'b0; cond_sel = '0;
    setflags_en = 1'b0; new_n = 1'b0; new_z = 1'b0; new_c = 1'b0; new_v = 1'b0;
    sat_event = 1'b0; sw_wr_en = 1'b0; sw_wr_data = '0;
    mdl = '0;
    tick(); tick();
    t_reset();
    t_all_conditions();
    t_compare();
    t_hold_and_update();
    t_sticky();
    t_write_priority();
    t_pre_update();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule